// File: doc/BRIEF.md
# Token-Chained Serial Event Readout

This block keeps one chip's digitised event record in a local RAM and, when granted access, sends it bit by bit onto a serial data line that many chips share. Access to the line moves down a daisy chain as a single token. A chip that is idle and sees its token input pulse starts its frame on the next clock. After the last bit it drops its line enable and pulses its token output for one clock, which becomes the next chip's token input.

A frame holds the chip's identifier, then one bunch-crossing number per stored column, then each column's time and charge slots. Every field is sent most significant bit first. The converter loads the RAM through a valid/ready write port. While a frame is being sent, ready is held low so that the record cannot change under the reader. A write held valid during that time simply waits and completes once the chip is idle again. There is no back-pressure on the serial side: the line is a raw bit stream at one bit per clock.

Top module: `tok_ro_fmt`

## Requirements
- R1: When `token_in` is high at a clock edge while the block is idle, `line_en` rises at that edge and stays high for exactly as many cycles as the frame has bits.
- R2: `line_data` is low in every cycle in which `line_en` is low.
- R3: The frame is sent MSB first, one bit per clock, in this order:
  - the 8-bit `chip_id`;
  - for columns 0 to n-1, bits 11:0 of each bunch-crossing slot;
  - for each column in turn, its NCH time slots and then its NCH charge slots, each as a full 16-bit slot.
- R4: The RAM map is as follows:
  - address c (0 ≤ c < NCOL) holds the bunch-crossing number of column c;
  - address NCOL + c·2·NCH + ch holds the time of channel ch;
  - address NCOL + c·2·NCH + NCH + ch holds its charge.
  - A data slot carries the hit flag in bit 15, the gain flag in bit 14, zeros in bits 13:12 and the 12-bit value in bits 11:0. It is sent unaltered.
- R5: `token_out` is high for exactly one cycle: the cycle right after the last frame bit, in which `line_en` is already low.
- R6: With `n_cols` = 0, the frame is only the 8 identifier bits, and the token is passed on straight after them.
- R7: An `n_cols` value above NCOL is treated as NCOL.
- R8: `wr_ready` is high exactly when no frame is in progress. A write is taken on `wr_valid && wr_ready`. A write held during a frame changes nothing in that frame and is taken once the block is idle.
- R9: A `token_in` pulse while a frame is in progress has no effect on the frame or on the token output.
- R10: After reset, `line_en`, `line_data` and `token_out` are low and `wr_ready` is high.
- R11: In a chain of instances, at most one drives `line_en` high in any cycle. Frames follow chain order, with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_id | input | ID_W | Identifier sent at the head of the frame |
| n_cols | input | CNT_W | Number of stored columns, sampled with the token |
| wr_valid | input | 1 | RAM write request |
| wr_ready | output | 1 | RAM write can be taken (idle) |
| wr_addr | input | clog2(NCOL·(2·NCH+1)) | RAM write address |
| wr_data | input | SLOT_W | RAM write slot |
| token_in | input | 1 | Token from the previous chip |
| token_out | output | 1 | One-cycle token to the next chip |
| line_en | output | 1 | This chip drives the shared line |
| line_data | output | 1 | Serial bit, forced low when not enabled |

## Verification
The hard cases are those that occur only in the middle of a frame. One is a write held valid against a slot the chip has not yet sent. The other is a second token pulse arriving while the chip is still transmitting. The bench runs three chained instances against a queue-based model of the whole chain. In one pass it raises a write on the first chip two cycles into its frame and holds it. It then checks that `wr_ready` stays low until the gap cycle, that the frame still carries the old slot, and that the next pass carries the new one. In another pass it pulses the first token input four cycles into the frame and expects no change to the stream.

// File: rtl/tok_ro_pkg.sv
package tok_ro_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ID, PH_BCID, PH_DATA} ph_e;
  typedef enum logic [1:0] {LD_ID, LD_BCID, LD_SLOT} ld_e;
endpackage

// File: rtl/tok_ro_ram.sv
module tok_ro_ram #(
  parameter int DEPTH = 1168,
  parameter int AW    = 11,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < (AW+1)'(DEPTH))) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  AST_RADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, raddr} < (AW+1)'(DEPTH)); // R4
endmodule

// File: rtl/tok_ro_seq.sv
module tok_ro_seq
  import tok_ro_pkg::*;
#(
  parameter int NCH    = 36,
  parameter int NCOL   = 16,
  parameter int ID_W   = 8,
  parameter int BCID_W = 12,
  parameter int SLOT_W = 16,
  parameter int AW     = 11,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             token_in,
  input  logic [CNT_W-1:0] n_cols,
  output logic             busy,
  output logic             token_out,
  output logic             ld,
  output ld_e              ld_sel,
  output logic [AW-1:0]    rd_addr
);
  localparam int BW     = $clog2(SLOT_W + 1);
  localparam int DBASE  = NCOL;
  localparam int DCNT_W = $clog2(NCOL * 2 * NCH + 1);

  ph_e               ph;
  logic [BW-1:0]     bits_left;
  logic [CNT_W-1:0]  ncol_q, bc_idx, ncol_clamp;
  logic [DCNT_W-1:0] dat_left, total;
  logic              last, fin;

  function automatic logic [BW-1:0] item_w(ld_e s);
    case (s)
      LD_ID:   return BW'(ID_W);
      LD_BCID: return BW'(BCID_W);
      default: return BW'(SLOT_W);
    endcase
  endfunction

  assign busy       = (ph != PH_IDLE);
  assign last       = busy && (bits_left == BW'(1));
  assign ncol_clamp = (n_cols > CNT_W'(NCOL)) ? CNT_W'(NCOL) : n_cols;
  assign total      = DCNT_W'(ncol_q) * DCNT_W'(2 * NCH);

  always_comb begin
    ld     = 1'b0;
    ld_sel = LD_ID;
    fin    = 1'b0;
    if (ph == PH_IDLE) begin
      ld = token_in;
    end else if (last) begin
      case (ph)
        PH_ID: begin
          if (ncol_q == '0) fin = 1'b1;
          else begin ld = 1'b1; ld_sel = LD_BCID; end
        end
        PH_BCID: begin
          ld     = 1'b1;
          ld_sel = (bc_idx < ncol_q) ? LD_BCID : LD_SLOT;
        end
        PH_DATA: begin
          if (dat_left == '0) fin = 1'b1;
          else begin ld = 1'b1; ld_sel = LD_SLOT; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      bits_left <= '0;
      ncol_q    <= '0;
      bc_idx    <= '0;
      dat_left  <= '0;
      rd_addr   <= '0;
      token_out <= 1'b0;
    end else begin
      token_out <= fin;
      if (fin) begin
        ph        <= PH_IDLE;
        bits_left <= '0;
        rd_addr   <= '0;
      end else if (ld) begin
        bits_left <= item_w(ld_sel);
        case (ld_sel)
          LD_ID: begin
            ph      <= PH_ID;
            ncol_q  <= ncol_clamp;
            bc_idx  <= '0;
            rd_addr <= '0;
          end
          LD_BCID: begin
            ph      <= PH_BCID;
            bc_idx  <= bc_idx + 1'b1;
            rd_addr <= ((bc_idx + 1'b1) < ncol_q) ? AW'(bc_idx + 1'b1) : AW'(DBASE);
          end
          default: begin
            if (ph == PH_BCID) begin
              ph       <= PH_DATA;
              dat_left <= total - 1'b1;
              rd_addr  <= AW'(DBASE + 1);
            end else begin
              dat_left <= dat_left - 1'b1;
              if (dat_left > DCNT_W'(1)) rd_addr <= rd_addr + 1'b1;
            end
          end
        endcase
      end else if (busy) begin
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  AST_TOKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out); // R5
  AST_TOKEN_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |-> (ph == PH_IDLE) && $past(ph != PH_IDLE)); // R5
  AST_START_ON_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(token_in)); // R1
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bits_left != '0); // R3
  AST_DATA_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA) |-> ({1'b0, rd_addr} < (AW+1)'(DBASE + NCOL * 2 * NCH))); // R4
  AST_COLS_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ncol_q <= CNT_W'(NCOL)); // R7
endmodule

// File: rtl/tok_ro_shift.sv
module tok_ro_shift
  import tok_ro_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int BCID_W = 12,
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  ld_e               ld_sel,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [SLOT_W-1:0] rd_q,
  input  logic              busy,
  output logic              line_en,
  output logic              line_data
);
  logic [SLOT_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (ld) begin
      case (ld_sel)
        LD_ID:   sreg <= SLOT_W'(chip_id) << (SLOT_W - ID_W);
        LD_BCID: sreg <= SLOT_W'(rd_q[BCID_W-1:0]) << (SLOT_W - BCID_W);
        default: sreg <= rd_q;
      endcase
    end else begin
      sreg <= sreg << 1;
    end
  end

  assign line_en   = busy;
  assign line_data = busy & sreg[SLOT_W-1];
endmodule

// File: rtl/tok_ro_fmt.sv
module tok_ro_fmt
  import tok_ro_pkg::*;
#(
  parameter int NCH    = 36,
  parameter int NCOL   = 16,
  parameter int ID_W   = 8,
  parameter int BCID_W = 12,
  parameter int SLOT_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ID_W-1:0]                     chip_id,
  input  logic [CNT_W-1:0]                    n_cols,
  input  logic                                wr_valid,
  output logic                                wr_ready,
  input  logic [$clog2(NCOL*(2*NCH+1))-1:0]   wr_addr,
  input  logic [SLOT_W-1:0]                   wr_data,
  input  logic                                token_in,
  output logic                                token_out,
  output logic                                line_en,
  output logic                                line_data
);
  localparam int DEPTH = NCOL * (2 * NCH + 1);
  localparam int AW    = $clog2(DEPTH);

  logic              busy, ld;
  ld_e               ld_sel;
  logic [AW-1:0]     rd_addr;
  logic [SLOT_W-1:0] rd_q;

  assign wr_ready = !busy;

  tok_ro_ram #(.DEPTH(DEPTH), .AW(AW), .W(SLOT_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_valid && wr_ready), .waddr(wr_addr),
    .wdata(wr_data), .raddr(rd_addr), .rdata(rd_q)
  );

  tok_ro_seq #(.NCH(NCH), .NCOL(NCOL), .ID_W(ID_W), .BCID_W(BCID_W),
               .SLOT_W(SLOT_W), .AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .token_in(token_in), .n_cols(n_cols),
    .busy(busy), .token_out(token_out), .ld(ld), .ld_sel(ld_sel), .rd_addr(rd_addr)
  );

  tok_ro_shift #(.ID_W(ID_W), .BCID_W(BCID_W), .SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_sel(ld_sel), .chip_id(chip_id),
    .rd_q(rd_q), .busy(busy), .line_en(line_en), .line_data(line_data)
  );

  AST_TOKEN_NOT_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |-> !line_en); // R5
  AST_NO_EARLY_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_en) |-> token_out); // R1
endmodule

// File: tb/tok_ro_fmt_tb_top.sv
module tok_ro_fmt_tb_top;
  localparam int NCH = 2, NCOL = 3, CNT_W = 4, ID_W = 8, BCID_W = 12, SLOT_W = 16;
  localparam int NCHIP = 3;
  localparam int DEPTH = NCOL * (2 * NCH + 1);
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tok0;
  logic [NCHIP-1:0] tin, tout, len, ldat, wv, wr;
  logic [AW-1:0]     wa  [NCHIP];
  logic [SLOT_W-1:0] wd  [NCHIP];
  logic [ID_W-1:0]   cid [NCHIP];
  logic [CNT_W-1:0]  nc  [NCHIP];

  for (genvar g = 0; g < NCHIP; g++) begin : g_chip
    if (g == 0) begin : g_head
      assign tin[g] = tok0;
    end else begin : g_link
      assign tin[g] = tout[g-1];
    end
    tok_ro_fmt #(.NCH(NCH), .NCOL(NCOL), .ID_W(ID_W), .BCID_W(BCID_W),
                 .SLOT_W(SLOT_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .chip_id(cid[g]), .n_cols(nc[g]),
      .wr_valid(wv[g]), .wr_ready(wr[g]), .wr_addr(wa[g]), .wr_data(wd[g]),
      .token_in(tin[g]), .token_out(tout[g]), .line_en(len[g]), .line_data(ldat[g])
    );
  end

  logic [SLOT_W-1:0] img [NCHIP][DEPTH];
  int  q_who[$];
  int  q_tok[$];
  bit  q_bit[$];
  int  nchk = 0, nfail = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void push_bits(int who, logic [SLOT_W-1:0] v, int w);
    for (int i = w - 1; i >= 0; i--) begin
      q_who.push_back(who); q_bit.push_back(v[i]); q_tok.push_back(-1);
    end
  endfunction

  function automatic int frame_len(int n);
    int c = (n > NCOL) ? NCOL : n;
    return ID_W + c * BCID_W + c * 2 * NCH * SLOT_W;
  endfunction

  function automatic void push_frame(int k, int n);
    int c = (n > NCOL) ? NCOL : n;
    push_bits(k, SLOT_W'(cid[k]), ID_W);
    for (int col = 0; col < c; col++) push_bits(k, img[k][col] & 16'h0FFF, BCID_W);
    for (int col = 0; col < c; col++)
      for (int j = 0; j < 2 * NCH; j++) push_bits(k, img[k][NCOL + col * 2 * NCH + j], SLOT_W);
    q_who.push_back(-1); q_bit.push_back(1'b0); q_tok.push_back(k);
  endfunction

  task automatic run_round(int n0, int n1, int n2, bit inj_tok, bit inj_wr, string tag);
    int ns[NCHIP];
    int en_cnt[NCHIP];
    int step = 0;
    bit drop = 1'b0;
    ns[0] = n0; ns[1] = n1; ns[2] = n2;
    for (int k = 0; k < NCHIP; k++) begin
      nc[k] = CNT_W'(ns[k]); en_cnt[k] = 0; push_frame(k, ns[k]);
    end
    @(negedge clk); tok0 = 1'b1;
    @(posedge clk);
    @(negedge clk); tok0 = 1'b0;
    while (q_who.size() > 0) begin
      int who = q_who.pop_front();
      bit b = q_bit.pop_front();
      int t = q_tok.pop_front();
      logic [NCHIP-1:0] ee = '0, et = '0;
      if (who >= 0) ee[who] = 1'b1;
      if (t >= 0) et[t] = 1'b1;
      chk(len == ee, "R1 R11", {tag, " line_en"}, int'(len), int'(ee));
      chk((ldat & ~len) == '0, "R2", {tag, " idle line"}, int'(ldat), 0);
      if (who >= 0) chk((|ldat) == b, "R3 R4", {tag, " line bit"}, int'(|ldat), int'(b));
      chk(tout == et, "R5", {tag, " token_out"}, int'(tout), int'(et));
      chk(wr == ~ee, "R8", {tag, " wr_ready"}, int'(wr), int'(~ee));
      for (int k = 0; k < NCHIP; k++) if (len[k]) en_cnt[k]++;
      if (inj_tok && step == 4) tok0 = 1'b1; // R9 stray token mid-frame
      if (inj_tok && step == 5) tok0 = 1'b0;
      if (drop) begin
        wv[0] = 1'b0; img[0][NCOL + 1] = wd[0]; drop = 1'b0;
      end
      if (inj_wr && step == 2) begin
        wv[0] = 1'b1; wa[0] = AW'(NCOL + 1); wd[0] = 16'h8ABC;
      end
      if (wv[0] && wr[0]) drop = 1'b1;
      step++;
      @(negedge clk);
    end
    if (drop) begin wv[0] = 1'b0; img[0][NCOL + 1] = wd[0]; end
    chk(len == '0 && tout == '0, "R5", {tag, " chain quiet"}, int'({len, tout}), 0);
    for (int k = 0; k < NCHIP; k++)
      chk(en_cnt[k] == frame_len(ns[k]),
          (ns[k] == 0) ? "R6" : (ns[k] > NCOL) ? "R7" : "R1",
          {tag, " frame length"}, en_cnt[k], frame_len(ns[k]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tok0 = 1'b0; wv = '0;
    cid[0] = 8'hA5; cid[1] = 8'h3C; cid[2] = 8'h01;
    for (int k = 0; k < NCHIP; k++) begin
      wa[k] = '0; wd[k] = '0; nc[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(len == '0 && ldat == '0, "R10", "reset line", int'({len, ldat}), 0);
    chk(tout == '0, "R10", "reset token", int'(tout), 0);
    chk(wr == '1, "R10", "reset ready", int'(wr), 7);
    // Load every chip's record, slots carry hit in bit 15 and gain in bit 14
    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 0; k < NCHIP; k++) begin
        logic [11:0] v = 12'((k * 97 + a * 53 + 11) & 12'hFFF);
        logic [SLOT_W-1:0] s = {1'(a & 1), 1'(k ^ (a >> 1)), 2'b00, v};
        if (a < NCOL) s = {4'b0000, v};
        img[k][a] = s; wv[k] = 1'b1; wa[k] = AW'(a); wd[k] = s;
      end
      @(posedge clk);
      @(negedge clk);
    end
    wv = '0;
    run_round(2, 0, 7, 1'b0, 1'b0, "round1");
    run_round(3, 1, 0, 1'b1, 1'b1, "round2");
    run_round(3, 3, 2, 1'b0, 1'b0, "round3 R8 R9");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule